// File: doc/BRIEF.md
# Queue Doorbell Pointer Tracker

This block holds the ring indices for a parameterised number of queue pairs. Each pair has one submission ring and one completion ring of the same size. The host moves the submission tail and the completion head by writing doorbell registers. The controller side moves the submission head when it takes an entry and the completion tail when it posts a completion. Queue pair 0 is the admin pair. All other pairs are I/O pairs, and the two types have different size limits.

Doorbells sit in a register window that starts at byte offset 0x1000, with a 4-byte stride. Queue `y` has its submission tail doorbell at 0x1000 + 8y and its completion head doorbell at 0x1000 + 8y + 4. A queue is created by loading its size. Creation clears all four pointers of the pair. The block reports empty, full and the pending submission count for every queue. It checks every doorbell value against the ring state. A value that cannot be legal is dropped and sets a sticky error bit.

Top module: `qdb_tracker`

## Requirements
- R1: After reset every queue pair is disabled, all pointers read 0, `db_err` is 0, and each disabled ring reports empty, not full and a pending count of 0.
- R2: A create for pair `q` with a size from 2 up to the type limit (4096 for pair 0, 65536 for others) enables the pair, stores the size and zeroes its four pointers. Any other size disables the pair and also zeroes its pointers. Create takes priority over every other update to the same pair in that cycle.
- R3: A write to 0x1000 + 8y targets the submission tail of pair y, and a write to 0x1000 + 8y + 4 targets the completion head of pair y. Writes to any other address change no pointer and do not set `db_err`.
- R4: A submission tail doorbell value v is accepted when v < size and ((v − tail) mod size) ≤ (size − 1 − pending). The tail then becomes v on the next clock.
- R5: A completion head doorbell value v is accepted when v < size and ((v − head) mod size) ≤ ((tail − head) mod size). The head then becomes v on the next clock.
- R6: A doorbell that fails its check, or that targets a disabled pair, leaves the pointers unchanged and sets `db_err`. `db_err` stays set until reset.
- R7: For an enabled ring, empty is head == tail and full is (tail + 1) mod size == head. `sq_pending` is (tail − head) mod size.
- R8: A consume on an enabled pair whose submission ring is not empty advances the submission head by one, wrapping to 0 at the size. A consume on an empty ring or a disabled pair has no effect.
- R9: A post on an enabled pair whose completion ring is not full advances the completion tail by one, wrapping to 0 at the size. A post on a full ring or a disabled pair has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_wr_en | input | 1 | Doorbell register write strobe |
| db_wr_addr | input | ADDR_W | Byte address of the doorbell write |
| db_wr_data | input | DATA_W | Doorbell value written |
| create_en | input | 1 | Load a size into one queue pair |
| create_qid | input | QID_W | Pair being created |
| create_size | input | 17 | Requested number of entries |
| consume_en | input | 1 | Controller took a submission entry |
| consume_qid | input | QID_W | Pair whose submission head advances |
| post_en | input | 1 | Controller posted a completion |
| post_qid | input | QID_W | Pair whose completion tail advances |
| q_enabled | output | NUM_QP | Pair holds a legal size |
| sq_empty | output | NUM_QP | Submission ring empty |
| sq_full | output | NUM_QP | Submission ring full |
| cq_empty | output | NUM_QP | Completion ring empty |
| cq_full | output | NUM_QP | Completion ring full |
| sq_pending | output | NUM_QP*16 | Pending submission entries per pair |
| sq_head | output | NUM_QP*16 | Submission head per pair |
| sq_tail | output | NUM_QP*16 | Submission tail per pair |
| cq_head | output | NUM_QP*16 | Completion head per pair |
| cq_tail | output | NUM_QP*16 | Completion tail per pair |
| db_err | output | 1 | Sticky rejected-doorbell flag |

## Verification
The assertions expect the select inputs to be stable and known at each clock edge. They also expect `consume_qid`, `post_qid` and `create_qid` to name existing pairs whenever their strobes are high. The stimulus draws every queue number from 0 to NUM_QP − 1 and holds every input for a full cycle, changing it only on the falling edge. Doorbell values are not restricted: the stimulus deliberately sends out-of-range values, values that overrun the opposite pointer, and writes to addresses outside the window. The checks therefore exercise both the accept path and the reject path, as well as doorbells that collide with a create in the same cycle.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
   localparam int IDX_W = 16;
   localparam int SZ_W  = IDX_W + 1;

   typedef logic [IDX_W-1:0] idx_t;
   typedef logic [SZ_W-1:0]  qsize_t;

   // distance travelled from b forward to a on a ring of the given size
   function automatic qsize_t ring_dist(input idx_t a, input idx_t b, input qsize_t size);
      qsize_t ea;
      qsize_t eb;
      ea = {1'b0, a};
      eb = {1'b0, b};
      if (a >= b) return ea - eb;
      return ea + size - eb;
   endfunction

   // index after a, wrapping to zero at the ring size
   function automatic idx_t ring_next(input idx_t a, input qsize_t size);
      qsize_t n;
      n = {1'b0, a} + qsize_t'(1);
      if (n >= size) return '0;
      return n[IDX_W-1:0];
   endfunction
endpackage

// File: rtl/qdb_decode.sv
module qdb_decode #(
   parameter int NUM_QP     = 4,
   parameter int ADDR_W     = 16,
   parameter int BASE_ADDR  = 'h1000,
   parameter int STRIDE_LG2 = 2
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_QP-1:0] sel_sq_tail,
   output logic [NUM_QP-1:0] sel_cq_head
);
   localparam int STRIDE   = 1 << STRIDE_LG2;
   localparam int WIN_END  = BASE_ADDR + 2 * NUM_QP * STRIDE;

   if (WIN_END > (1 << ADDR_W)) begin : g_bad_window
      $error("doorbell window does not fit in the address width");
   end
   if (STRIDE_LG2 < 2) begin : g_bad_stride
      $error("doorbell stride must be at least 4 bytes");
   end

   for (genvar q = 0; q < NUM_QP; q++) begin : g_q
      localparam int SQ_OFF = BASE_ADDR + (2 * q) * STRIDE;
      localparam int CQ_OFF = BASE_ADDR + (2 * q + 1) * STRIDE;
      assign sel_sq_tail[q] = wr_en && (addr == ADDR_W'(SQ_OFF));
      assign sel_cq_head[q] = wr_en && (addr == ADDR_W'(CQ_OFF));
   end
endmodule

// File: rtl/qdb_ring.sv
module qdb_ring
   import qdb_pkg::*;
#(
   parameter int MAX_ENTRIES = 65536,
   parameter int DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              create,
   input  qsize_t            create_size,
   input  logic              sq_db,
   input  logic              cq_db,
   input  logic [DATA_W-1:0] db_val,
   input  logic              consume,
   input  logic              post,
   output logic              en,
   output idx_t              sq_head,
   output idx_t              sq_tail,
   output idx_t              cq_head,
   output idx_t              cq_tail,
   output idx_t              sq_pending,
   output logic              sq_empty,
   output logic              sq_full,
   output logic              cq_empty,
   output logic              cq_full,
   output logic              db_bad
);
   localparam qsize_t MAX_SZ = qsize_t'(MAX_ENTRIES);

   if (MAX_ENTRIES < 2 || MAX_ENTRIES > (1 << IDX_W)) begin : g_bad_max
      $error("queue limit must lie between 2 and 2**IDX_W");
   end
   if (DATA_W < SZ_W) begin : g_bad_data
      $error("doorbell data must be wider than the size field");
   end

   qsize_t size_q;
   qsize_t sq_cnt, sq_free, sq_adv, cq_cnt, cq_adv;
   idx_t   val_idx;
   logic   val_in_range, create_ok, sq_ok, cq_ok;

   assign val_idx      = db_val[IDX_W-1:0];
   assign val_in_range = db_val < DATA_W'(size_q);
   assign create_ok    = (create_size >= qsize_t'(2)) && (create_size <= MAX_SZ);

   assign sq_cnt  = ring_dist(sq_tail, sq_head, size_q);
   assign sq_free = en ? (size_q - sq_cnt - qsize_t'(1)) : '0;
   assign sq_adv  = ring_dist(val_idx, sq_tail, size_q);
   assign sq_ok   = en && val_in_range && (sq_adv <= sq_free);

   assign cq_cnt  = ring_dist(cq_tail, cq_head, size_q);
   assign cq_adv  = ring_dist(val_idx, cq_head, size_q);
   assign cq_ok   = en && val_in_range && (cq_adv <= cq_cnt);

   assign sq_empty   = (sq_head == sq_tail);
   assign cq_empty   = (cq_head == cq_tail);
   assign sq_full    = en && (ring_next(sq_tail, size_q) == sq_head);
   assign cq_full    = en && (ring_next(cq_tail, size_q) == cq_head);
   assign sq_pending = sq_cnt[IDX_W-1:0];
   assign db_bad     = (sq_db && !sq_ok) || (cq_db && !cq_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         size_q  <= '0;
         sq_head <= '0;
         sq_tail <= '0;
         cq_head <= '0;
         cq_tail <= '0;
      end else if (create) begin
         en      <= create_ok;
         size_q  <= create_ok ? create_size : '0;
         sq_head <= '0;
         sq_tail <= '0;
         cq_head <= '0;
         cq_tail <= '0;
      end else begin
         if (sq_db && sq_ok)              sq_tail <= val_idx;
         if (consume && en && !sq_empty)  sq_head <= ring_next(sq_head, size_q);
         if (cq_db && cq_ok)              cq_head <= val_idx;
         if (post && en && !cq_full)      cq_tail <= ring_next(cq_tail, size_q);
      end
   end

   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (size_q >= qsize_t'(2) && size_q <= MAX_SZ)); // R2
   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (sq_empty && cq_empty && !sq_full && !cq_full)); // R1
   AST_SQ_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ({1'b0, sq_head} < size_q && {1'b0, sq_tail} < size_q)); // R4
   AST_CQ_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ({1'b0, cq_head} < size_q && {1'b0, cq_tail} < size_q)); // R5
   AST_BAD_SQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_db && !sq_ok && !create) |=> $stable(sq_tail)); // R6
   AST_BAD_CQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cq_db && !cq_ok && !create) |=> $stable(cq_head)); // R6
   AST_PENDING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ({1'b0, sq_pending} < size_q)); // R7
   AST_EMPTY_NO_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && sq_empty && !create) |=> $stable(sq_head)); // R8
   AST_FULL_NO_POST: assert property (@(posedge clk) disable iff (!rst_n)
      (post && cq_full && !create) |=> $stable(cq_tail)); // R9
endmodule

// File: rtl/qdb_tracker.sv
module qdb_tracker
   import qdb_pkg::*;
#(
   parameter int NUM_QP     = 4,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int BASE_ADDR  = 'h1000,
   parameter int STRIDE_LG2 = 2,
   parameter int ADMIN_MAX  = 4096,
   parameter int IO_MAX     = 65536,
   localparam int QID_W     = (NUM_QP > 1) ? $clog2(NUM_QP) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    db_wr_en,
   input  logic [ADDR_W-1:0]       db_wr_addr,
   input  logic [DATA_W-1:0]       db_wr_data,
   input  logic                    create_en,
   input  logic [QID_W-1:0]        create_qid,
   input  logic [SZ_W-1:0]         create_size,
   input  logic                    consume_en,
   input  logic [QID_W-1:0]        consume_qid,
   input  logic                    post_en,
   input  logic [QID_W-1:0]        post_qid,
   output logic [NUM_QP-1:0]       q_enabled,
   output logic [NUM_QP-1:0]       sq_empty,
   output logic [NUM_QP-1:0]       sq_full,
   output logic [NUM_QP-1:0]       cq_empty,
   output logic [NUM_QP-1:0]       cq_full,
   output logic [NUM_QP*IDX_W-1:0] sq_pending,
   output logic [NUM_QP*IDX_W-1:0] sq_head,
   output logic [NUM_QP*IDX_W-1:0] sq_tail,
   output logic [NUM_QP*IDX_W-1:0] cq_head,
   output logic [NUM_QP*IDX_W-1:0] cq_tail,
   output logic                    db_err
);
   if (NUM_QP < 1 || NUM_QP > 1024) begin : g_bad_qp
      $error("NUM_QP must lie between 1 and 1024");
   end

   logic [NUM_QP-1:0] sel_sq, sel_cq, bad;

   qdb_decode #(
      .NUM_QP(NUM_QP), .ADDR_W(ADDR_W),
      .BASE_ADDR(BASE_ADDR), .STRIDE_LG2(STRIDE_LG2)
   ) u_decode (
      .wr_en(db_wr_en), .addr(db_wr_addr),
      .sel_sq_tail(sel_sq), .sel_cq_head(sel_cq)
   );

   for (genvar q = 0; q < NUM_QP; q++) begin : g_pair
      localparam int LIMIT = (q == 0) ? ADMIN_MAX : IO_MAX;
      qdb_ring #(.MAX_ENTRIES(LIMIT), .DATA_W(DATA_W)) u_ring (
         .clk(clk), .rst_n(rst_n),
         .create(create_en && (create_qid == QID_W'(q))),
         .create_size(create_size),
         .sq_db(sel_sq[q]), .cq_db(sel_cq[q]), .db_val(db_wr_data),
         .consume(consume_en && (consume_qid == QID_W'(q))),
         .post(post_en && (post_qid == QID_W'(q))),
         .en(q_enabled[q]),
         .sq_head(sq_head[q*IDX_W +: IDX_W]), .sq_tail(sq_tail[q*IDX_W +: IDX_W]),
         .cq_head(cq_head[q*IDX_W +: IDX_W]), .cq_tail(cq_tail[q*IDX_W +: IDX_W]),
         .sq_pending(sq_pending[q*IDX_W +: IDX_W]),
         .sq_empty(sq_empty[q]), .sq_full(sq_full[q]),
         .cq_empty(cq_empty[q]), .cq_full(cq_full[q]),
         .db_bad(bad[q])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) db_err <= 1'b0;
      else        db_err <= db_err | (|bad);
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      db_err |=> db_err); // R6
   AST_ONE_DB_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_sq, sel_cq})); // R3
   AST_NO_ERR_WITHOUT_DB: assert property (@(posedge clk) disable iff (!rst_n)
      (!db_err && !db_wr_en) |=> !db_err); // R3
endmodule

// File: tb/tb_qdb_tracker.sv
`timescale 1ns/1ps
module tb_qdb_tracker;
   localparam int NQ   = 4;
   localparam int AW   = 16;
   localparam int BASE = 'h1000;
   localparam int QW   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          db_wr_en = 0;
   logic [AW-1:0] db_wr_addr = '0;
   logic [31:0]   db_wr_data = '0;
   logic          create_en = 0;
   logic [QW-1:0] create_qid = '0;
   logic [16:0]   create_size = '0;
   logic          consume_en = 0;
   logic [QW-1:0] consume_qid = '0;
   logic          post_en = 0;
   logic [QW-1:0] post_qid = '0;
   logic [NQ-1:0] q_enabled, sq_empty, sq_full, cq_empty, cq_full;
   logic [NQ*16-1:0] sq_pending, sq_head, sq_tail, cq_head, cq_tail;
   logic          db_err;

   qdb_tracker #(.NUM_QP(NQ), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n),
      .db_wr_en(db_wr_en), .db_wr_addr(db_wr_addr), .db_wr_data(db_wr_data),
      .create_en(create_en), .create_qid(create_qid), .create_size(create_size),
      .consume_en(consume_en), .consume_qid(consume_qid),
      .post_en(post_en), .post_qid(post_qid),
      .q_enabled(q_enabled), .sq_empty(sq_empty), .sq_full(sq_full),
      .cq_empty(cq_empty), .cq_full(cq_full), .sq_pending(sq_pending),
      .sq_head(sq_head), .sq_tail(sq_tail), .cq_head(cq_head), .cq_tail(cq_tail),
      .db_err(db_err)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit  m_en[NQ];
   int  m_size[NQ];
   int  m_sqh[NQ], m_sqt[NQ], m_cqh[NQ], m_cqt[NQ];
   bit  m_err;

   function automatic int rmod(input int a, input int s);
      return ((a % s) + s) % s;
   endfunction

   always @(posedge clk) begin
      int off, dq, lim;
      bit dhit, dhead;
      longint v;
      int n_sqh[NQ], n_sqt[NQ], n_cqh[NQ], n_cqt[NQ];
      if (!rst_n) begin
         for (int q = 0; q < NQ; q++) begin
            m_en[q] = 0; m_size[q] = 0;
            m_sqh[q] = 0; m_sqt[q] = 0; m_cqh[q] = 0; m_cqt[q] = 0;
         end
         m_err = 0;
      end else begin
         for (int q = 0; q < NQ; q++) begin
            n_sqh[q] = m_sqh[q]; n_sqt[q] = m_sqt[q];
            n_cqh[q] = m_cqh[q]; n_cqt[q] = m_cqt[q];
         end
         dhit = 0; dq = 0; dhead = 0;
         if (db_wr_en && int'(db_wr_addr) >= BASE) begin
            off = int'(db_wr_addr) - BASE;
            if (off % 4 == 0 && off / 8 < NQ) begin
               dhit = 1; dq = off / 8; dhead = ((off / 4) % 2) == 1;
            end
         end
         if (dhit) begin
            v = longint'(db_wr_data);
            if (!m_en[dq] || v >= m_size[dq]) m_err = 1;
            else if (!dhead) begin
               if (rmod(int'(v) - m_sqt[dq], m_size[dq]) >
                   m_size[dq] - 1 - rmod(m_sqt[dq] - m_sqh[dq], m_size[dq])) m_err = 1;
               else n_sqt[dq] = int'(v);
            end else begin
               if (rmod(int'(v) - m_cqh[dq], m_size[dq]) >
                   rmod(m_cqt[dq] - m_cqh[dq], m_size[dq])) m_err = 1;
               else n_cqh[dq] = int'(v);
            end
         end
         if (consume_en && m_en[consume_qid] && m_sqh[consume_qid] != m_sqt[consume_qid])
            n_sqh[consume_qid] = (m_sqh[consume_qid] + 1) % m_size[consume_qid];
         if (post_en && m_en[post_qid] &&
             (m_cqt[post_qid] + 1) % m_size[post_qid] != m_cqh[post_qid])
            n_cqt[post_qid] = (m_cqt[post_qid] + 1) % m_size[post_qid];
         for (int q = 0; q < NQ; q++) begin
            m_sqh[q] = n_sqh[q]; m_sqt[q] = n_sqt[q];
            m_cqh[q] = n_cqh[q]; m_cqt[q] = n_cqt[q];
         end
         if (create_en) begin
            lim = (create_qid == 0) ? 4096 : 65536;
            dq = int'(create_qid);
            m_en[dq] = (create_size >= 2) && (int'(create_size) <= lim);
            m_size[dq] = m_en[dq] ? int'(create_size) : 0;
            m_sqh[dq] = 0; m_sqt[dq] = 0; m_cqh[dq] = 0; m_cqt[dq] = 0;
         end
      end
   end

   // compare every output with the model on each falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int q = 0; q < NQ; q++) begin
            chk($sformatf("R2 q%0d enabled", q), longint'(q_enabled[q]), longint'(m_en[q]));
            chk($sformatf("R4 q%0d sq_tail", q), longint'(sq_tail[q*16 +: 16]), m_sqt[q]);
            chk($sformatf("R5 q%0d cq_head", q), longint'(cq_head[q*16 +: 16]), m_cqh[q]);
            chk($sformatf("R8 q%0d sq_head", q), longint'(sq_head[q*16 +: 16]), m_sqh[q]);
            chk($sformatf("R9 q%0d cq_tail", q), longint'(cq_tail[q*16 +: 16]), m_cqt[q]);
            chk($sformatf("R7 q%0d sq_empty", q), longint'(sq_empty[q]), longint'(m_sqh[q] == m_sqt[q]));
            chk($sformatf("R7 q%0d cq_empty", q), longint'(cq_empty[q]), longint'(m_cqh[q] == m_cqt[q]));
            chk($sformatf("R7 q%0d sq_full", q), longint'(sq_full[q]),
                longint'(m_en[q] && (m_sqt[q] + 1) % m_size[q] == m_sqh[q]));
            chk($sformatf("R7 q%0d cq_full", q), longint'(cq_full[q]),
                longint'(m_en[q] && (m_cqt[q] + 1) % m_size[q] == m_cqh[q]));
            chk($sformatf("R7 q%0d pending", q), longint'(sq_pending[q*16 +: 16]),
                m_en[q] ? rmod(m_sqt[q] - m_sqh[q], m_size[q]) : 0);
         end
         chk("R6 db_err", longint'(db_err), longint'(m_err));
      end
   end

   task automatic clear_inputs();
      db_wr_en = 0; create_en = 0; consume_en = 0; post_en = 0;
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); clear_inputs(); end
   endtask
   task automatic mk(input int q, input int sz);
      @(negedge clk); clear_inputs();
      create_en = 1; create_qid = QW'(q); create_size = 17'(sz);
   endtask
   task automatic db(input int addr, input longint val);
      @(negedge clk); clear_inputs();
      db_wr_en = 1; db_wr_addr = AW'(addr); db_wr_data = 32'(val);
   endtask
   task automatic cons(input int q);
      @(negedge clk); clear_inputs(); consume_en = 1; consume_qid = QW'(q);
   endtask
   task automatic post(input int q);
      @(negedge clk); clear_inputs(); post_en = 1; post_qid = QW'(q);
   endtask
   task automatic do_reset();
      @(negedge clk); clear_inputs(); #1 rst_n = 0;
      repeat (2) @(negedge clk);
      #1 rst_n = 1;
   endtask

   function automatic int sqa(input int q); return BASE + 8 * q; endfunction
   function automatic int cqa(input int q); return BASE + 8 * q + 4; endfunction

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      idle(1);
      // R1 reset state checked at the ports
      chk("R1 enabled after reset", longint'(q_enabled), 0);
      chk("R1 error after reset", longint'(db_err), 0);
      chk("R1 empty after reset", longint'(sq_empty & cq_empty), longint'({NQ{1'b1}}));

      // R2 creation limits
      mk(0, 4096); idle(1);
      chk("R2 admin 4096 accepted", longint'(q_enabled[0]), 1);
      mk(0, 4097); idle(1);
      chk("R2 admin 4097 refused", longint'(q_enabled[0]), 0);
      mk(0, 1); mk(0, 4); mk(1, 65536); mk(2, 65537); idle(1);
      chk("R2 io 65537 refused", longint'(q_enabled[2]), 0);
      mk(2, 2); mk(3, 8); idle(1);
      chk("R2 io 65536 accepted", longint'(q_enabled[1]), 1);

      // R3 addresses outside the doorbell slots
      db(BASE - 8, 1); db(BASE + 2, 1); db(BASE + 8 * NQ, 1); db(BASE + 8 * NQ + 4, 1); idle(1);
      chk("R3 stray writes no error", longint'(db_err), 0);
      chk("R3 stray writes no tail move", longint'(sq_tail), 0);

      // R4 and R8 on pair 3 (size 8)
      db(sqa(3), 5); cons(3); cons(3); cons(3); idle(1);
      chk("R8 head after three takes", longint'(sq_head[3*16 +: 16]), 3);
      db(sqa(3), 2); idle(1);
      chk("R4 wrap to full", longint'(sq_full[3]), 1);
      chk("R7 pending when full", longint'(sq_pending[3*16 +: 16]), 7);
      for (int i = 0; i < 8; i++) cons(3);
      idle(1);
      chk("R8 empty after drain", longint'(sq_empty[3]), 1);
      chk("R8 head wrapped", longint'(sq_head[3*16 +: 16]), 2);
      cons(2); cons(0); idle(1);

      // R9 and R5 on pair 2 (size 2) and pair 1 (size 65536)
      post(2); post(2); idle(1);
      chk("R9 full at one entry", longint'(cq_full[2]), 1);
      chk("R9 tail held when full", longint'(cq_tail[2*16 +: 16]), 1);
      db(cqa(2), 1); idle(1);
      chk("R5 head release", longint'(cq_empty[2]), 1);
      post(1); post(1); post(1); db(cqa(1), 2); idle(1);
      chk("R5 big ring head", longint'(cq_head[1*16 +: 16]), 2);
      chk("R6 no error yet", longint'(db_err), 0);

      // R6 rejected doorbells
      db(sqa(3), 8); idle(1);
      chk("R6 out of range sets error", longint'(db_err), 1);
      chk("R6 tail unchanged", longint'(sq_tail[3*16 +: 16]), 2);
      db(cqa(1), 65535); db(cqa(2), 0); db(sqa(3), 64'h1_0000_0002); idle(2);
      chk("R6 error stays set", longint'(db_err), 1);
      chk("R6 cq head unchanged", longint'(cq_head[1*16 +: 16]), 2);

      // mixed random traffic, including same-cycle collisions
      for (int i = 0; i < 1500; i++) begin
         @(negedge clk); clear_inputs();
         if ($urandom_range(0, 2) == 0) begin
            db_wr_en = 1;
            db_wr_addr = AW'(BASE + 4 * $urandom_range(0, 2 * NQ));
            db_wr_data = 32'($urandom_range(0, 9));
         end
         if ($urandom_range(0, 1) == 0) begin consume_en = 1; consume_qid = QW'($urandom_range(0, NQ-1)); end
         if ($urandom_range(0, 1) == 0) begin post_en = 1; post_qid = QW'($urandom_range(0, NQ-1)); end
         if ($urandom_range(0, 60) == 0) begin
            create_en = 1; create_qid = QW'($urandom_range(0, NQ-1));
            create_size = 17'($urandom_range(1, 9));
         end
         if (i == 700) begin clear_inputs(); #1 rst_n = 0; end
         if (i == 702) begin #1 rst_n = 1; end
         if (i == 704) begin for (int q = 0; q < NQ; q++) begin create_en = 1; create_qid = QW'(q); create_size = 17'(q + 3); end end
      end
      idle(2);

      do_reset(); idle(1);
      chk("R1 error cleared by reset", longint'(db_err), 0);
      chk("R1 disabled after reset", longint'(q_enabled), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule